// File: doc/BRIEF.md
# Prioritized Level Interrupt Controller

This block sits beside a processor core. Interrupt sources are grouped into numbered levels, and each level owns a wide pending mask with one bit per source. A per-level status vector records which levels have at least one source pending. The status is combined with a software request vector. A priority scan then finds the highest active level, and that level is compared with the core's current priority level. When it is strictly higher, the block raises an interrupt request and latches the chosen level together with a summary of the contributing bits. Later, when the core's trap logic pulses a commit strobe, the latched pair is copied into the interrupt-summary and interrupt-ID output registers.

Every pin is a plain control or register pin. Post, clear and clear-all are single-cycle strobes that are accepted in the cycle they are presented, so the block has no back-pressure and no valid/ready pair. All decisions are registered: a decision about the interrupt request appears one clock edge after the inputs that caused it are sampled.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: A post with an in-range level L (0..31) and source S (0..63) sets bit S of level L's mask. After the same clock edge, bit L of `lvl_status` is 1.
- R2: An in-range clear resets the addressed source bit. Bit L of `lvl_status` drops only when level L's mask is zero after the clear. If a post and a clear address the same level in one cycle, the post wins.
- R3: `clr_all` zeroes every mask and the whole status vector at one edge, and it overrides a post or clear in the same cycle.
- R4: `int_pending` is registered and equals "status nonzero and `pc_lo` == 0", using the status and `pc_lo` of the previous cycle. A nonzero `pc_lo` also blocks `irq_req` at the next edge.
- R5: The candidate level is found by a scan in two parts.
  - If any `lvl_status` bit in the external range 16..31 is set, the level is the highest such index.
  - Otherwise, the highest set `sw_req` bit i in the software range 1..15 gives level i − 1 + 1.
  - If neither holds, the level is 0.
  - The summary is (`sw_req` AND bits 1..15) OR (`lvl_status` AND bits 16..31).
  - Status bits 0..15 and `sw_req` bits 0 and 16..31 never affect the level.
- R6: An interrupt is taken when the level is nonzero, strictly greater than `cur_ipl`, `pc_lo` is 0 and `async_trap` is 0. `irq_req` is 1 in the cycle after a take.
- R7: A take latches the level and summary and sets `info_valid`. Each later take overwrites the latch.
- R8: A commit while `info_valid` is 1 copies the latched summary to `isr_out` and the latched level to `intid_out`. It clears `info_valid` unless a take happens in the same cycle.
- R9: A commit while `info_valid` is 0 pulses `commit_err` for one cycle and leaves `isr_out` and `intid_out` unchanged.
- R10: A nonzero `async_trap` sets `trap_err` at the next edge and blocks any take.
- R11: A post or clear with a level ≥ 32 or a source ≥ 64 changes no state and pulses `cmd_err` for one cycle.
- R12: A synchronous active-high `rst` clears all masks, status, latch, valid flag, output registers and error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_en | input | 1 | Post strobe |
| post_level | input | 6 | Level addressed by a post |
| post_src | input | 7 | Source bit addressed by a post |
| clr_en | input | 1 | Clear strobe |
| clr_level | input | 6 | Level addressed by a clear |
| clr_src | input | 7 | Source bit addressed by a clear |
| clr_all | input | 1 | Clear every mask and status bit |
| pc_lo | input | 2 | Two low bits of the current PC |
| sw_req | input | 32 | Software interrupt request register |
| cur_ipl | input | 5 | Current interrupt priority level |
| async_trap | input | 4 | Asynchronous trap request register (unsupported) |
| commit | input | 1 | Copy latched info to output registers |
| lvl_status | output | 32 | Per-level status vector |
| int_pending | output | 1 | Registered pending indication |
| irq_req | output | 1 | Interrupt request, one cycle after a take |
| info_valid | output | 1 | Latched level/summary awaiting commit |
| isr_out | output | 32 | Interrupt-summary register |
| intid_out | output | 5 | Interrupt-ID register |
| cmd_err | output | 1 | Out-of-range post or clear |
| commit_err | output | 1 | Commit without valid latched info |
| trap_err | output | 1 | Asynchronous trap request seen |

## Verification
The hardest case to reach from the ports is a commit that lands in the same cycle as a fresh take. In that cycle the output registers must receive the old latch, and the valid flag must stay set. To bring this about, the bench keeps the priority level low so that a take happens every cycle, and it fires the strobe in the middle of that run. The rest of the stimulus is a sweep. It covers every software bit against every priority level, and every external level against the priority values at and around it. It also runs a two-source post/clear pattern on each of the 32 levels, so the "status drops only on an empty mask" rule is exercised everywhere.

// File: rtl/lic_pkg.sv
package lic_pkg;
  // Map a software request bit position onto its priority level.
  function automatic int sw_bit_to_level(input int bit_idx, input int sw_lo);
    return bit_idx - sw_lo + 1;
  endfunction

  // Build a mask with ones over [lo..hi].
  function automatic logic [63:0] range_mask(input int lo, input int hi);
    logic [63:0] m;
    m = '0;
    for (int i = lo; i <= hi; i++) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/lic_src_bank.sv
module lic_src_bank #(
  parameter int NUM_LEVELS = 32,
  parameter int SRC_W      = 64,
  parameter int LIDX_W     = 6,
  parameter int SIDX_W     = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  post_en,
  input  logic [LIDX_W-1:0]     post_level,
  input  logic [SIDX_W-1:0]     post_src,
  input  logic                  clr_en,
  input  logic [LIDX_W-1:0]     clr_level,
  input  logic [SIDX_W-1:0]     clr_src,
  input  logic                  clr_all,
  output logic [NUM_LEVELS-1:0] status_o,
  output logic                  cmd_err_o
);
  logic post_ok, clr_ok, err_q;
  logic [SRC_W-1:0] post_bits, clr_bits;

  assign post_ok = post_en && (post_level < LIDX_W'(NUM_LEVELS)) && (post_src < SIDX_W'(SRC_W));
  assign clr_ok  = clr_en  && (clr_level  < LIDX_W'(NUM_LEVELS)) && (clr_src  < SIDX_W'(SRC_W));
  assign post_bits = SRC_W'(1) << post_src;
  assign clr_bits  = SRC_W'(1) << clr_src;

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= (post_en && !post_ok) || (clr_en && !clr_ok);
  end
  assign cmd_err_o = err_q;

  for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_lvl
    logic             post_hit, clr_hit, st_q;
    logic [SRC_W-1:0] mask_q, mask_nx;

    assign post_hit = post_ok && (post_level == LIDX_W'(l));
    assign clr_hit  = clr_ok  && (clr_level  == LIDX_W'(l));
    assign mask_nx  = (mask_q & ~(clr_hit ? clr_bits : '0)) | (post_hit ? post_bits : '0);

    always_ff @(posedge clk) begin
      if (rst || clr_all) mask_q <= '0;
      else                mask_q <= mask_nx;
    end

    always_ff @(posedge clk) begin
      if (rst || clr_all)                 st_q <= 1'b0;
      else if (post_hit)                  st_q <= 1'b1;
      else if (clr_hit && mask_nx == '0)  st_q <= 1'b0;
    end
    assign status_o[l] = st_q;

    // R2
    status_tracks_mask_chk: assert property (@(posedge clk) disable iff (rst)
      st_q == (|mask_q));
  end

  // R3
  clr_all_empties_chk: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> (status_o == '0));

  // R11
  bad_cmd_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (post_en && !post_ok) |=> cmd_err_o);

  // R1
  post_sets_status_chk: assert property (@(posedge clk) disable iff (rst)
    (post_ok && !clr_all) |=> status_o[$past(post_level[$clog2(NUM_LEVELS)-1:0])]);
endmodule

// File: rtl/lic_prio_enc.sv
module lic_prio_enc #(
  parameter int NUM_LEVELS = 32,
  parameter int LVL_W      = 5,
  parameter int SW_LO      = 1,
  parameter int SW_HI      = 15,
  parameter int EXT_LO     = 16,
  parameter int EXT_HI     = 31
) (
  input  logic [NUM_LEVELS-1:0] status_i,
  input  logic [NUM_LEVELS-1:0] sw_req_i,
  output logic [LVL_W-1:0]      level_o,
  output logic [NUM_LEVELS-1:0] summary_o
);
  import lic_pkg::*;

  // Software scan first, external scan second: the last active bit wins.
  always_comb begin
    level_o   = '0;
    summary_o = '0;
    for (int i = SW_LO; i <= SW_HI; i++) begin
      if (sw_req_i[i]) begin
        level_o      = LVL_W'(sw_bit_to_level(i, SW_LO));
        summary_o[i] = 1'b1;
      end
    end
    for (int i = EXT_LO; i <= EXT_HI; i++) begin
      if (status_i[i]) begin
        level_o      = LVL_W'(i);
        summary_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lic_take_unit.sv
module lic_take_unit #(
  parameter int NUM_LEVELS = 32,
  parameter int LVL_W      = 5,
  parameter int AST_W      = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [LVL_W-1:0]      cand_level,
  input  logic [NUM_LEVELS-1:0] cand_summary,
  input  logic [LVL_W-1:0]      cur_ipl,
  input  logic [1:0]            pc_lo,
  input  logic [AST_W-1:0]      async_trap,
  input  logic                  commit,
  output logic                  irq_req,
  output logic                  info_valid,
  output logic [NUM_LEVELS-1:0] isr_out,
  output logic [LVL_W-1:0]      intid_out,
  output logic                  commit_err,
  output logic                  trap_err
);
  logic                  take;
  logic [LVL_W-1:0]      lat_level;
  logic [NUM_LEVELS-1:0] lat_summary;

  assign take = (cand_level != '0) && (cand_level > cur_ipl) &&
                (pc_lo == 2'b00) && (async_trap == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req     <= 1'b0;
      info_valid  <= 1'b0;
      lat_level   <= '0;
      lat_summary <= '0;
      isr_out     <= '0;
      intid_out   <= '0;
      commit_err  <= 1'b0;
      trap_err    <= 1'b0;
    end else begin
      irq_req    <= take;
      trap_err   <= |async_trap;
      commit_err <= commit && !info_valid;
      if (commit && info_valid) begin
        isr_out   <= lat_summary;
        intid_out <= lat_level;
      end
      if (take) begin
        lat_level   <= cand_level;
        lat_summary <= cand_summary;
        info_valid  <= 1'b1;
      end else if (commit) begin
        info_valid  <= 1'b0;
      end
    end
  end

  // R7
  req_has_info_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> info_valid);

  // R9
  bad_commit_keeps_regs_chk: assert property (@(posedge clk) disable iff (rst)
    commit_err |-> ($stable(isr_out) && $stable(intid_out)));

  // R10
  trap_blocks_req_chk: assert property (@(posedge clk) disable iff (rst)
    (async_trap != '0) |=> (trap_err && !irq_req));
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl #(
  parameter int NUM_LEVELS = 32,
  parameter int SRC_W      = 64,
  parameter int SW_LO      = 1,
  parameter int SW_HI      = 15,
  parameter int EXT_LO     = 16,
  parameter int EXT_HI     = 31,
  parameter int AST_W      = 4,
  localparam int LVL_W     = $clog2(NUM_LEVELS),
  localparam int LIDX_W    = LVL_W + 1,
  localparam int SIDX_W    = $clog2(SRC_W) + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  post_en,
  input  logic [LIDX_W-1:0]     post_level,
  input  logic [SIDX_W-1:0]     post_src,
  input  logic                  clr_en,
  input  logic [LIDX_W-1:0]     clr_level,
  input  logic [SIDX_W-1:0]     clr_src,
  input  logic                  clr_all,
  input  logic [1:0]            pc_lo,
  input  logic [NUM_LEVELS-1:0] sw_req,
  input  logic [LVL_W-1:0]      cur_ipl,
  input  logic [AST_W-1:0]      async_trap,
  input  logic                  commit,
  output logic [NUM_LEVELS-1:0] lvl_status,
  output logic                  int_pending,
  output logic                  irq_req,
  output logic                  info_valid,
  output logic [NUM_LEVELS-1:0] isr_out,
  output logic [LVL_W-1:0]      intid_out,
  output logic                  cmd_err,
  output logic                  commit_err,
  output logic                  trap_err
);
  logic [LVL_W-1:0]      cand_level;
  logic [NUM_LEVELS-1:0] cand_summary;

  lic_src_bank #(.NUM_LEVELS(NUM_LEVELS), .SRC_W(SRC_W), .LIDX_W(LIDX_W), .SIDX_W(SIDX_W)) u_bank (
    .clk(clk), .rst(rst),
    .post_en(post_en), .post_level(post_level), .post_src(post_src),
    .clr_en(clr_en), .clr_level(clr_level), .clr_src(clr_src),
    .clr_all(clr_all), .status_o(lvl_status), .cmd_err_o(cmd_err)
  );

  lic_prio_enc #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W), .SW_LO(SW_LO), .SW_HI(SW_HI),
                 .EXT_LO(EXT_LO), .EXT_HI(EXT_HI)) u_enc (
    .status_i(lvl_status), .sw_req_i(sw_req),
    .level_o(cand_level), .summary_o(cand_summary)
  );

  lic_take_unit #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W), .AST_W(AST_W)) u_take (
    .clk(clk), .rst(rst),
    .cand_level(cand_level), .cand_summary(cand_summary),
    .cur_ipl(cur_ipl), .pc_lo(pc_lo), .async_trap(async_trap), .commit(commit),
    .irq_req(irq_req), .info_valid(info_valid), .isr_out(isr_out),
    .intid_out(intid_out), .commit_err(commit_err), .trap_err(trap_err)
  );

  always_ff @(posedge clk) begin
    if (rst) int_pending <= 1'b0;
    else     int_pending <= (|lvl_status) && (pc_lo == 2'b00);
  end

  // R4
  misaligned_pc_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_lo != 2'b00) |=> (!irq_req && !int_pending));

  // R12
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (lvl_status == '0 && !info_valid && !irq_req && isr_out == '0));
endmodule

// File: tb/lvl_irq_ctrl_tb.sv
module lvl_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        post_en = 0, clr_en = 0, clr_all = 0, commit = 0;
  logic [5:0]  post_level = 0, clr_level = 0;
  logic [6:0]  post_src = 0, clr_src = 0;
  logic [1:0]  pc_lo = 0;
  logic [31:0] sw_req = 0;
  logic [4:0]  cur_ipl = 0;
  logic [3:0]  async_trap = 0;
  logic [31:0] lvl_status, isr_out;
  logic        int_pending, irq_req, info_valid, cmd_err, commit_err, trap_err;
  logic [4:0]  intid_out;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lvl_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .post_en(post_en), .post_level(post_level), .post_src(post_src),
    .clr_en(clr_en), .clr_level(clr_level), .clr_src(clr_src), .clr_all(clr_all),
    .pc_lo(pc_lo), .sw_req(sw_req), .cur_ipl(cur_ipl), .async_trap(async_trap),
    .commit(commit), .lvl_status(lvl_status), .int_pending(int_pending), .irq_req(irq_req),
    .info_valid(info_valid), .isr_out(isr_out), .intid_out(intid_out), .cmd_err(cmd_err),
    .commit_err(commit_err), .trap_err(trap_err)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_post(input int l, input int s);
    post_en = 1; post_level = 6'(l); post_src = 7'(s);
    tick();
    post_en = 0;
  endtask

  task automatic do_clr(input int l, input int s);
    clr_en = 1; clr_level = 6'(l); clr_src = 7'(s);
    tick();
    clr_en = 0;
  endtask

  task automatic do_clr_all();
    clr_all = 1; tick(); clr_all = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp_st;
    repeat (3) tick();
    rst = 0;
    // R12 reset state
    chk("R12 status", lvl_status, 0);
    chk("R12 valid", info_valid, 0);
    chk("R12 irq", irq_req, 0);
    chk("R12 isr", isr_out, 0);
    chk("R12 intid", intid_out, 0);
    chk("R12 pending", int_pending, 0);

    // R1 / R2 sweep over every level with two sources
    sw_req = 0; cur_ipl = 5'd31;
    for (int l = 0; l < 32; l++) begin
      int sa, sb;
      sa = (l * 5 + 3) % 64;
      sb = (l * 11 + 60) % 64;
      if (sb == sa) sb = sa ^ 1;
      do_post(l, sa);
      chk("R1 post sets level", lvl_status, 64'(32'(1) << l));
      do_post(l, sb);
      do_clr(l, sa);
      chk("R2 clear keeps nonempty level", lvl_status, 64'(32'(1) << l));
      do_clr(l, sb);
      chk("R2 clear drops empty level", lvl_status, 0);
    end

    // R3 post+clear same bit, then clear_all overriding a post
    do_post(3, 7);
    do_post(20, 1);
    post_en = 1; post_level = 6'd9; post_src = 7'd2;
    clr_en = 1; clr_level = 6'd9; clr_src = 7'd2;
    tick(); post_en = 0; clr_en = 0;
    exp_st = (32'(1) << 3) | (32'(1) << 20) | (32'(1) << 9);
    chk("R3 post wins over clear", lvl_status, exp_st);
    clr_all = 1; post_en = 1; post_level = 6'd4; post_src = 7'd0;
    tick(); clr_all = 0; post_en = 0;
    chk("R3 clear_all empties", lvl_status, 0);
    do_clr(4, 0);
    chk("R3 no stale source after clear_all", lvl_status, 0);

    // R11 out-of-range commands
    do_post(32, 0);
    chk("R11 bad level err", cmd_err, 1);
    chk("R11 bad level no state", lvl_status, 0);
    tick();
    chk("R11 err is one cycle", cmd_err, 0);
    do_post(3, 0);
    do_clr(3, 64);
    chk("R11 bad source err", cmd_err, 1);
    chk("R11 bad source no state", lvl_status, 32'(1) << 3);

    // R4 pending and PC alignment
    pc_lo = 2'd0; tick();
    chk("R4 pending aligned", int_pending, 1);
    for (int p = 1; p < 4; p++) begin
      pc_lo = 2'(p); tick();
      chk("R4 pending blocked misaligned", int_pending, 0);
    end
    pc_lo = 0;

    // R5 status below external range does not make a level
    do_clr_all();
    do_post(5, 9);
    cur_ipl = 0; sw_req = 0; tick(); tick();
    chk("R5 low status gives no request", irq_req, 0);
    chk("R5 low status still pending", int_pending, 1);
    do_clr_all();

    // R5 / R6 software sweep across every priority level
    for (int s = 1; s < 16; s++) begin
      for (int ipl = 0; ipl < 32; ipl++) begin
        sw_req = ((32'(2) << s) - 1) | 32'hFFFF_0000;
        cur_ipl = 5'(ipl);
        tick();
        chk("R6 software take vs ipl", irq_req, (s > ipl) ? 1 : 0);
      end
    end

    // R5 / R7 / R8 external sweep with commit
    cur_ipl = 5'd31; sw_req = 32'hFFFF_FFFF;
    tick(); commit = 1; tick(); commit = 0;
    for (int e = 16; e < 32; e++) begin
      do_clr_all();
      do_post(e, e);
      cur_ipl = 5'(e); tick();
      chk("R6 equal level no take", irq_req, 0);
      cur_ipl = 5'(e - 1); tick();
      chk("R6 one above ipl takes", irq_req, 1);
      chk("R7 valid after take", info_valid, 1);
      cur_ipl = 5'd31; tick();
      chk("R6 ipl max no take", irq_req, 0);
      commit = 1; tick(); commit = 0;
      chk("R8 isr from summary", isr_out, 32'h0000_FFFE | (32'(1) << e));
      chk("R8 intid from level", intid_out, e);
      chk("R8 valid cleared", info_valid, 0);
    end

    // R8 commit with simultaneous take keeps valid
    do_clr_all();
    do_post(18, 0);
    sw_req = 0; cur_ipl = 0; tick();
    do_clr_all();
    do_post(25, 3);
    tick();
    commit = 1; tick(); commit = 0;
    chk("R8 commit+take keeps valid", info_valid, 1);
    chk("R8 commit+take copies latch", intid_out, 25);
    cur_ipl = 5'd31; tick();
    commit = 1; tick(); commit = 0;
    chk("R8 valid drops", info_valid, 0);

    // R9 commit without valid
    commit = 1; tick(); commit = 0;
    chk("R9 commit err", commit_err, 1);
    chk("R9 isr unchanged", isr_out, 32'(1) << 25);
    chk("R9 intid unchanged", intid_out, 25);
    tick();
    chk("R9 err one cycle", commit_err, 0);

    // R10 asynchronous trap request
    cur_ipl = 0; async_trap = 4'h2; tick();
    chk("R10 trap err", trap_err, 1);
    chk("R10 no take", irq_req, 0);
    async_trap = 0; tick();
    chk("R10 take resumes", irq_req, 1);

    // R4 misaligned PC blocks the request
    pc_lo = 2'd2; tick();
    chk("R4 misaligned blocks irq", irq_req, 0);
    pc_lo = 0;

    // R12 reset mid-run
    rst = 1; tick(); rst = 0;
    chk("R12 reset status", lvl_status, 0);
    chk("R12 reset valid", info_valid, 0);
    chk("R12 reset intid", intid_out, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule